// File: doc/BRIEF.md
# Channelized Signaling PCM Output Stream

This block turns per-channel signaling state into a serial PCM-style stream. The output has one 8-bit slot for every channel timeslot and runs in step with the receive voice data. Each slot carries that channel's four signaling bits in its low nibble. An upstream extractor writes ABCD values into a shadow store at any time. The serial output reads from a separate output copy. That copy changes only when a multiframe sync arrives, and only while the freeze input is low.

Slot and bit alignment come from two backplane timing inputs: a frame sync and a multiframe sync. Both restart the slot counter. Because the block follows these inputs and ignores line-side framing, the signaling can be re-timed to a backplane alignment that differs from the line alignment. The frame has 32 slots of 8 bits, which gives 256 bit clocks per frame. Timeslots 0 and 16 carry no voice channel and always output zeros.

Top module: `sig_pcm_stream`

## Requirements
- R1: While reset is asserted, and up to the first multiframe load after it, the output is low in every bit and both buffers hold zero.
- R2: On the clock edge that samples the frame sync high, the output moves to bit 0 of slot 0. After that it advances one bit per clock, so slot k bit j appears 8k+j clocks after the sync edge.
- R3: With no sync, the bit position counts up to 255 and then wraps to slot 0 bit 0.
- R4: Bits go out MSB first. Bits 0 to 3 of each slot (the upper nibble) are always 0. Bits 4, 5, 6 and 7 carry wr_abcd_i[3] (A), [2] (B), [1] (C) and [0] (D) of the value last loaded for that slot.
- R5: Slots 0 and 16 output all zeros, even when the extractor has written data to them.
- R6: A shadow write has no effect on the output until a multiframe sync loads it.
- R7: When a multiframe sync is sampled with freeze low, the output copy takes every shadow write made before that edge. The new values are visible from slot 0 of that frame.
- R8: A multiframe sync sampled with freeze high leaves the output copy unchanged. The shadow keeps accepting writes, and the next unfrozen multiframe sync delivers the latest values.
- R9: The multiframe sync also restarts the slot position, exactly as the frame sync does. A sync that arrives mid-frame realigns the stream at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backplane bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_i | input | 1 | Frame sync, one-clock pulse at slot 0 bit 0 |
| mfs_i | input | 1 | Multiframe sync, one-clock pulse; loads the output copy and realigns |
| freeze_i | input | 1 | Blocks the multiframe load while high |
| wr_en_i | input | 1 | Shadow write strobe from the extractor |
| wr_slot_i | input | 5 | Timeslot written |
| wr_abcd_i | input | 4 | Signaling value, A in bit 3 |
| sig_o | output | 1 | Serial signaling stream |

## Verification
The hardest situation to reach from the ports is a load that skips a frozen multiframe. The shadow must keep collecting writes across that boundary, and the output must still show the older copy. The stimulus fills the shadow during a frame that ends in a frozen multiframe sync. It writes again during the following frame, then issues an unfrozen sync. It then compares every bit of the next frame against the most recent writes. Mid-frame resyncs, including a multiframe sync with no frame sync, are placed after partial frames of irregular length, so that a realignment error shows up as shifted bits.

// File: rtl/sig_pcm_pkg.sv
package sig_pcm_pkg;
    localparam int SLOTS_DEF     = 32;
    localparam int SLOT_BITS_DEF = 8;
    localparam int SIG_W_DEF     = 4;
    localparam int CAS_SLOT_DEF  = 16;

    typedef enum logic [1:0] {
        BIT_BLANK = 2'd0,
        BIT_PAD   = 2'd1,
        BIT_SIG   = 2'd2
    } bit_kind_e;
endpackage

// File: rtl/sig_pcm_timer.sv
module sig_pcm_timer #(
    parameter int SLOTS = 32,
    parameter int SLOT_BITS = 8,
    localparam int POS_W = $clog2(SLOTS * SLOT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic [POS_W-1:0] pos_q_o,
    output logic [POS_W-1:0] pos_d_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(SLOTS * SLOT_BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i || st_q.pos == LAST) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q_o = st_q.pos;
    assign pos_d_o = st_d.pos;

    // R2 / R9: a sync restarts the position
    a_r2_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> pos_q_o == '0);
    // R3: wrap at the end of the frame
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && pos_q_o == LAST) |=> pos_q_o == '0);
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && pos_q_o != LAST) |=> pos_q_o == $past(pos_q_o) + 1'b1);
endmodule

// File: rtl/sig_pcm_shadow.sv
module sig_pcm_shadow #(
    parameter int SLOTS = 32,
    parameter int SIG_W = 4,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [SLOT_W-1:0]           wr_slot_i,
    input  logic [SIG_W-1:0]            wr_sig_i,
    output logic [SLOTS-1:0][SIG_W-1:0] shadow_o
);
    typedef struct packed {
        logic [SLOTS-1:0][SIG_W-1:0] mem;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.mem[wr_slot_i] = wr_sig_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.mem;

    // R6: only the addressed slot changes
    a_r6_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> shadow_o[$past(wr_slot_i)] == $past(wr_sig_i));
    a_r6_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(shadow_o));
endmodule

// File: rtl/sig_pcm_serial.sv
module sig_pcm_serial
    import sig_pcm_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int SLOT_BITS = 8,
    parameter int SIG_W = 4,
    parameter int CAS_SLOT = 16,
    localparam int POS_W = $clog2(SLOTS * SLOT_BITS),
    localparam int BIT_W = $clog2(SLOT_BITS),
    localparam int NIB_W = (SIG_W > 1) ? $clog2(SIG_W) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic                        freeze_i,
    input  logic [SLOTS-1:0][SIG_W-1:0] shadow_i,
    input  logic [POS_W-1:0]            pos_d_i,
    output logic                        sig_o
);
    localparam logic [BIT_W-1:0] SIG_START = BIT_W'(SLOT_BITS - SIG_W);
    localparam logic [BIT_W-1:0] TOP_BIT   = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        logic [SLOTS-1:0][SIG_W-1:0] act;
        logic                        sig;
    } state_t;

    state_t st_d, st_q;

    logic [SLOTS-1:0] blank_mask;
    for (genvar g = 0; g < SLOTS; g++) begin : g_blank
        assign blank_mask[g] = (g == 0) || (g == CAS_SLOT);
    end

    logic [POS_W-BIT_W-1:0] slot_n;
    logic [BIT_W-1:0]       bit_n;
    logic [BIT_W-1:0]       rev_n;
    bit_kind_e              kind_n;

    always_comb begin
        slot_n = pos_d_i[POS_W-1:BIT_W];
        bit_n  = pos_d_i[BIT_W-1:0];
        rev_n  = TOP_BIT - bit_n;
        if (blank_mask[slot_n]) begin
            kind_n = BIT_BLANK;
        end else if (bit_n < SIG_START) begin
            kind_n = BIT_PAD;
        end else begin
            kind_n = BIT_SIG;
        end
    end

    always_comb begin
        st_d = st_q;
        if (load_i && !freeze_i) begin
            st_d.act = shadow_i;
        end
        case (kind_n)
            BIT_SIG: st_d.sig = st_d.act[slot_n][rev_n[NIB_W-1:0]];
            default: st_d.sig = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_o = st_q.sig;

    // R6 / R8: the output copy holds unless an unfrozen multiframe load occurs
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && !freeze_i) |=> $stable(st_q.act));
    // R7: an unfrozen load captures the shadow
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !freeze_i) |=> st_q.act == $past(shadow_i));
endmodule

// File: rtl/sig_pcm_stream.sv
module sig_pcm_stream
    import sig_pcm_pkg::*;
#(
    parameter int SLOTS = SLOTS_DEF,
    parameter int SLOT_BITS = SLOT_BITS_DEF,
    parameter int SIG_W = SIG_W_DEF,
    parameter int CAS_SLOT = CAS_SLOT_DEF,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int POS_W = $clog2(SLOTS * SLOT_BITS),
    localparam int BIT_W = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_i,
    input  logic              mfs_i,
    input  logic              freeze_i,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [SIG_W-1:0]  wr_abcd_i,
    output logic              sig_o
);
    logic [SLOTS-1:0][SIG_W-1:0] shadow;
    logic [POS_W-1:0]            pos_q;
    logic [POS_W-1:0]            pos_d;

    sig_pcm_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (fs_i | mfs_i),
        .pos_q_o (pos_q),
        .pos_d_o (pos_d)
    );

    sig_pcm_shadow #(.SLOTS(SLOTS), .SIG_W(SIG_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_slot_i (wr_slot_i),
        .wr_sig_i  (wr_abcd_i),
        .shadow_o  (shadow)
    );

    sig_pcm_serial #(
        .SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .SIG_W(SIG_W), .CAS_SLOT(CAS_SLOT)
    ) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (mfs_i),
        .freeze_i (freeze_i),
        .shadow_i (shadow),
        .pos_d_i  (pos_d),
        .sig_o    (sig_o)
    );

    // R4: the upper nibble of every slot is zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[BIT_W-1:0] < BIT_W'(SLOT_BITS - SIG_W)) |-> !sig_o);
    // R5: the non-voice slots stay zero
    a_r5_blank_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q[POS_W-1:BIT_W] == '0 || pos_q[POS_W-1:BIT_W] == (POS_W-BIT_W)'(CAS_SLOT))
        |-> !sig_o);
endmodule

// File: tb/sig_pcm_stream_test.sv
module sig_pcm_stream_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs_i = 1'b0;
    logic       mfs_i = 1'b0;
    logic       freeze_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [4:0] wr_slot_i = '0;
    logic [3:0] wr_abcd_i = '0;
    logic       sig_o;

    int checks = 0;
    int errors = 0;
    int exp_pos = 0;
    logic [3:0] exp_sh [32];
    logic [3:0] exp_act [32];

    always #10 clk = ~clk;

    sig_pcm_stream uut (
        .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .mfs_i(mfs_i), .freeze_i(freeze_i),
        .wr_en_i(wr_en_i), .wr_slot_i(wr_slot_i), .wr_abcd_i(wr_abcd_i), .sig_o(sig_o)
    );

    task automatic check_out(input string tag);
        int slot;
        int b;
        logic e;
        string t;
        slot = exp_pos / 8;
        b = exp_pos % 8;
        t = tag;
        if (slot == 0 || slot == 16) begin
            e = 1'b0; t = "R5";
        end else if (b < 4) begin
            e = 1'b0; t = "R4";
        end else begin
            e = exp_act[slot][7-b];
        end
        checks++;
        if (sig_o !== e) begin
            errors++;
            $display("FAIL %s pos %0d: sig_o=%b expected %b", t, exp_pos, sig_o, e);
        end
    endtask

    task automatic tick(input bit sfs, input bit smfs, input bit frz, input bit wen,
                        input int slot, input int data, input string tag);
        fs_i = sfs;
        mfs_i = smfs;
        freeze_i = frz;
        wr_en_i = wen;
        wr_slot_i = 5'(slot);
        wr_abcd_i = 4'(data);
        if (smfs && !frz) begin
            for (int k = 0; k < 32; k++) exp_act[k] = exp_sh[k];
        end
        if (wen) exp_sh[slot] = 4'(data);
        @(negedge clk);
        exp_pos = (sfs || smfs) ? 0 : (exp_pos + 1) % 256;
        check_out(tag);
    endtask

    task automatic run_frame(input bit use_fs, input bit m, input bit frz, input bit wr_on,
                             input int seed, input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            tick(use_fs && i == 0, m && i == 0, frz, wr_on, i % 32,
                 (seed + (i % 32) * 3 + i / 32) % 16, tag);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            exp_sh[k] = '0;
            exp_act[k] = '0;
        end
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (sig_o !== 1'b0) begin
                errors++;
                $display("FAIL R1 in reset: sig_o=%b expected 0", sig_o);
            end
        end
        rst_n = 1'b1;
        exp_pos = 0;
        // R1 / R6: buffers start empty; writes go only to the shadow
        run_frame(1, 0, 0, 1, 0, 256, "R1");
        run_frame(1, 0, 0, 1, 5, 256, "R6");
        // R7: unfrozen multiframe load
        run_frame(1, 1, 0, 0, 0, 256, "R7");
        // R4 / R2: sweep every value through every slot
        for (int s = 0; s < 16; s++) run_frame(1, 1, 0, 1, s, 256, "R4");
        run_frame(1, 1, 0, 0, 0, 256, "R2");
        // R8: frozen load, further writes, then unfrozen load
        run_frame(1, 0, 0, 1, 9, 256, "R8");
        run_frame(1, 1, 1, 1, 12, 256, "R8");
        run_frame(1, 0, 0, 1, 11, 256, "R8");
        run_frame(1, 1, 0, 0, 0, 256, "R8");
        // R3: no sync, position wraps
        run_frame(0, 0, 0, 0, 0, 256, "R3");
        run_frame(0, 0, 0, 0, 0, 100, "R3");
        // R9: mid-frame realignment by frame sync and by multiframe sync alone
        run_frame(1, 0, 0, 1, 2, 77, "R9");
        run_frame(1, 1, 0, 1, 4, 133, "R9");
        run_frame(0, 1, 0, 1, 6, 256, "R9");
        run_frame(0, 0, 0, 0, 0, 256, "R3");
        run_frame(1, 1, 0, 0, 0, 256, "R2");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule